// File: doc/BRIEF.md
# Match Timer with Watchdog Reset Sequencer

This block runs a 32-bit up-counter that advances on every clock and compares it against four match registers. Each compare channel raises a sticky status bit on equality, and an enable mask decides which of those bits drive the four interrupt lines. Software uses it as a system tick source: it programs a match value a chosen number of counts ahead of the counter, waits for the interrupt, and then acknowledges the status bit.

The last channel can also act as a watchdog. Once software arms the watchdog, it cannot disarm it. A match on that channel then starts a reset-request pulse of fixed length. Software can request the same pulse directly through a one-shot command word. The block also keeps a record of why the system was last reset. A power-on reset sets that record to "hardware". Software resets, watchdog expiries and wake-from-sleep resets each add their own bit.

The block has two reset inputs. `por_n` is the power-on reset and clears everything. `sys_rst_n` is the ordinary system reset: it clears the timing state but keeps the watchdog arming and the reset record. All register accesses use word addresses: 0..3 are the match values, 4 is the counter, 5 is match status, 6 is the watchdog arm, 7 is the interrupt enable, 8 is the software-reset command and 9 is the reset cause. A read of any other address returns zero.

The reset sequencer is a two-state machine. In `RQ_IDLE`, the transition *fire* happens when an armed watchdog match or a software command occurs, and leads to `RQ_HOLD`. In `RQ_HOLD`, `rst_req` is high and a hold counter advances. The transition *expire* returns to `RQ_IDLE` after the hold counter has covered `HOLD_CYCLES` cycles. Triggers that arrive while in `RQ_HOLD` do not lengthen the pulse.

Top module: `match_wdt_timer`

## Requirements
- R1: The counter resets to 0, increases by one on every clock, wraps from 0xFFFFFFFF to 0, and a bus write to address 4 loads it; it reads back as the loaded value plus one on the cycle after the loading edge.
- R2: Match registers (addresses 0..3) reset to 0xFFFFFFFF; status bit n (address 5, bit n) becomes 1 on the edge after a cycle in which the counter equals match register n.
- R3: Status bits are cleared by writing 1 to them; writing 1 in the same cycle as a match on that channel leaves the bit at 1.
- R4: irq[n] is high exactly when status bit n and interrupt-enable bit n (address 7, bit n) are both 1.
- R5: Writing 1 to bit 0 of address 6 arms the watchdog; writing 0 does not disarm it; it reads back as bit 0 of address 6.
- R6: With the watchdog armed, a match on channel 3 drives rst_req high for exactly 4 cycles, starting on the edge after the matching cycle; with it unarmed, a channel 3 match never raises rst_req.
- R7: Writing 1 to bit 0 of address 8 drives rst_req high for 4 cycles starting at the write edge and sets cause bit 1; writing 0 there does nothing; address 8 reads as 0.
- R8: Cause register (address 9) bits are: 0 hardware, 1 software, 2 watchdog, 3 sleep wake (set by a high cycle on sleep_rst_evt); each bit is cleared by writing 1 to it.
- R9: While por_n is low, the cause register becomes 0x1, the watchdog is disarmed and rst_req is low.
- R10: sys_rst_n low resets the counter, match registers, status and interrupt enables, but leaves the watchdog arming and the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| sleep_rst_evt | input | 1 | One-cycle flag that a wake-from-sleep reset occurred |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | System reset request pulse |

## Verification
A wrong counter value or match register stays hidden until a status bit is set early, late or not at all. That shows up at address 5 or on irq one edge after the intended compare cycle. A fault in the reset sequencer shows up directly on rst_req: the pulse starts an edge early or late, or its length differs from four cycles. The bench therefore samples rst_req on every cycle of a predicted window. A fault in the sticky or set-only registers only shows up on a later read of addresses 6 and 9. The bench reads those addresses right after each write of zero, each collision and each system reset.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int N_CHAN  = 4;
    localparam int N_CAUSE = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_MATCH0 = 4'd0,
        A_MATCH1 = 4'd1,
        A_MATCH2 = 4'd2,
        A_MATCH3 = 4'd3,
        A_COUNT  = 4'd4,
        A_STATUS = 4'd5,
        A_WDOG   = 4'd6,
        A_IRQEN  = 4'd7,
        A_SWRST  = 4'd8,
        A_CAUSE  = 4'd9
    } reg_addr_e;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_HOLD = 1'b1
    } rq_state_e;

    localparam int CAUSE_HW    = 0;
    localparam int CAUSE_SW    = 1;
    localparam int CAUSE_WDOG  = 2;
    localparam int CAUSE_SLEEP = 3;
endpackage

// File: rtl/mwt_counter.sv
module mwt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    // R1: with no load the value steps by exactly one (wrap included)
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/mwt_match_chan.sv
module mwt_match_chan #(
    parameter int         W       = 32,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         wr_match,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] match_val,
    output logic         hit,
    output logic         status
);
    always_comb hit = (cnt == match_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_val <= RST_VAL;
        end else if (wr_match) begin
            match_val <= wdata;
        end
    end

    // set wins over a same-cycle write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (hit) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

    // R2: equality sets the sticky bit on the next edge
    a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status);
    // R3: a clear without a competing hit drops the bit
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !status);
endmodule

// File: rtl/mwt_reset_ctrl.sv
module mwt_reset_ctrl
    import mwt_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               wdog_arm,
    input  logic               wdog_hit,
    input  logic               sw_req,
    input  logic               sleep_evt,
    input  logic [N_CAUSE-1:0] cause_clr,
    output logic               wdog_en,
    output logic [N_CAUSE-1:0] cause,
    output logic               rst_req
);
    localparam int HC_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HOLD_CYCLES - 1);

    rq_state_e         state;
    logic [HC_W-1:0]   hcnt;
    logic              wd_fire;
    logic              fire;
    logic [N_CAUSE-1:0] cause_set;

    always_comb begin
        wd_fire = wdog_en && wdog_hit;
        fire    = wd_fire || sw_req;
        cause_set = '0;
        cause_set[CAUSE_SW]    = sw_req;
        cause_set[CAUSE_WDOG]  = wd_fire;
        cause_set[CAUSE_SLEEP] = sleep_evt;
    end

    // set-only arming, cleared only by power-on
    always_ff @(posedge clk) begin
        if (!por_n) begin
            wdog_en <= 1'b0;
        end else if (wdog_arm) begin
            wdog_en <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause <= N_CAUSE'(1) << CAUSE_HW;
        end else begin
            cause <= (cause & ~cause_clr) | cause_set;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state <= RQ_IDLE;
            hcnt  <= '0;
        end else begin
            unique case (state)
                RQ_IDLE: begin
                    if (fire) begin
                        state <= RQ_HOLD;
                        hcnt  <= '0;
                    end
                end
                RQ_HOLD: begin
                    if (hcnt == HC_LAST) begin
                        state <= RQ_IDLE;
                    end else begin
                        hcnt <= hcnt + HC_W'(1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            RQ_IDLE: rst_req = 1'b0;
            RQ_HOLD: rst_req = 1'b1;
        endcase
    end

    // R5: once armed, stays armed until power-on
    a_r5_arm_sticky: assert property (@(posedge clk) disable iff (!por_n)
        wdog_en |=> wdog_en);
    // R6: an accepted trigger raises the request on the next edge
    a_r6_fire_starts: assert property (@(posedge clk) disable iff (!por_n)
        (state == RQ_IDLE && fire) |=> rst_req);
    // R6: armed watchdog hit is recorded
    a_r6_wd_cause: assert property (@(posedge clk) disable iff (!por_n)
        wd_fire |=> cause[CAUSE_WDOG]);
    // R7: software command is recorded
    a_r7_sw_cause: assert property (@(posedge clk) disable iff (!por_n)
        sw_req |=> cause[CAUSE_SW]);
endmodule

// File: rtl/match_wdt_timer.sv
module match_wdt_timer
    import mwt_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int WD_CHAN     = N_CHAN - 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              sleep_rst_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CHAN-1:0] irq,
    output logic              rst_req
);
    localparam int CH_W = $clog2(N_CHAN);

    logic               rst_all_n;
    logic               we;
    logic [DATA_W-1:0]  cnt;
    logic [DATA_W-1:0]  match_val [N_CHAN];
    logic [N_CHAN-1:0]  hit;
    logic [N_CHAN-1:0]  status;
    logic [N_CHAN-1:0]  irq_en;
    logic [N_CHAN-1:0]  wr_match;
    logic [N_CHAN-1:0]  st_clr;
    logic               wdog_en;
    logic [N_CAUSE-1:0] cause;
    logic [N_CAUSE-1:0] cause_clr;
    logic               sw_req;
    logic               wdog_arm;

    always_comb begin
        rst_all_n = por_n && sys_rst_n;
        we        = bus_sel && bus_wr;
        st_clr    = (we && bus_addr == A_STATUS) ? bus_wdata[N_CHAN-1:0] : '0;
        cause_clr = (we && bus_addr == A_CAUSE) ? bus_wdata[N_CAUSE-1:0] : '0;
        sw_req    = we && (bus_addr == A_SWRST) && bus_wdata[0];
        wdog_arm  = we && (bus_addr == A_WDOG) && bus_wdata[0];
    end

    mwt_counter #(.W(DATA_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .ld     (we && bus_addr == A_COUNT),
        .ld_val (bus_wdata),
        .cnt    (cnt)
    );

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        always_comb wr_match[i] = we && (bus_addr == ADDR_W'(i));

        mwt_match_chan #(.W(DATA_W), .RST_VAL('1)) u_chan (
            .clk       (clk),
            .rst_n     (rst_all_n),
            .cnt       (cnt),
            .wr_match  (wr_match[i]),
            .wdata     (bus_wdata),
            .clr       (st_clr[i]),
            .match_val (match_val[i]),
            .hit       (hit[i]),
            .status    (status[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            irq_en <= '0;
        end else if (we && bus_addr == A_IRQEN) begin
            irq_en <= bus_wdata[N_CHAN-1:0];
        end
    end

    always_comb irq = status & irq_en;

    mwt_reset_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_rstctl (
        .clk       (clk),
        .por_n     (por_n),
        .wdog_arm  (wdog_arm),
        .wdog_hit  (hit[WD_CHAN]),
        .sw_req    (sw_req),
        .sleep_evt (sleep_rst_evt),
        .cause_clr (cause_clr),
        .wdog_en   (wdog_en),
        .cause     (cause),
        .rst_req   (rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(N_CHAN)) begin
            bus_rdata = match_val[bus_addr[CH_W-1:0]];
        end else begin
            case (bus_addr)
                A_COUNT:  bus_rdata = cnt;
                A_STATUS: bus_rdata = {{(DATA_W-N_CHAN){1'b0}}, status};
                A_WDOG:   bus_rdata = {{(DATA_W-1){1'b0}}, wdog_en};
                A_IRQEN:  bus_rdata = {{(DATA_W-N_CHAN){1'b0}}, irq_en};
                A_CAUSE:  bus_rdata = {{(DATA_W-N_CAUSE){1'b0}}, cause};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R4: an interrupt line never rises unless its channel status is set
    a_r4_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_all_n)
        $rose(irq[0]) |-> status[0]);
    // R9: power-on leaves only the hardware cause bit
    a_r9_por_cause: assert property (@(posedge clk)
        !por_n |=> (cause == N_CAUSE'(1)));
    // R10: system reset alone keeps the watchdog arming
    a_r10_keep_arm: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && wdog_en) |=> wdog_en);
endmodule

// File: tb/test_match_wdt_timer.sv
`timescale 1ns/1ps
module test_match_wdt_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        sleep_rst_evt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rst_req;

    always #5 clk = ~clk;

    match_wdt_timer i_match_wdt_timer (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .sleep_rst_evt(sleep_rst_evt), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 rst_req
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    logic      pending = 1'b0;
    int        n_run = 0;
    int        n_fail = 0;
    logic      done = 1'b0;

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (pending) begin
            exp_item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {28'd0, irq};
                default: act = {31'd0, rst_req};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
            pending = 1'b0;
        end
    end

    task automatic expect_item(input int kind, input logic [3:0] addr,
                               input logic [31:0] exp, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        bus_addr = addr;
        it.kind = kind; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        pending = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic rd(input logic [3:0] addr, input logic [31:0] exp, input string tag);
        expect_item(0, addr, exp, tag);
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] data);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1; por_n = 1'b1; sys_rst_n = 1'b1;

        // reset state
        rd(4'd9, 32'h1, "R9 cause after power-on");
        rd(4'd6, 32'h0, "R9 watchdog disarmed");
        rd(4'd5, 32'h0, "R2 status clear after reset");
        rd(4'd3, 32'hFFFF_FFFF, "R2 match reset value");
        expect_item(1, 4'd0, 32'h0, "R4 irq low after reset");
        expect_item(2, 4'd0, 32'h0, "R6 rst_req low after reset");

        // counter load, step and wrap
        wr(4'd4, 32'h0000_1234);
        rd(4'd4, 32'h0000_1235, "R1 load then step");
        wr(4'd4, 32'hFFFF_FFFE);
        rd(4'd4, 32'hFFFF_FFFF, "R1 step to max");
        rd(4'd4, 32'h0000_0000, "R1 wrap to zero");
        rd(4'd5, 32'hF, "R2 all-ones match hit on all channels");
        wr(4'd5, 32'hF);
        rd(4'd5, 32'h0, "R3 write-one clears all");

        // single channel match and interrupt gating
        wr(4'd0, 32'd500);
        wr(4'd4, 32'd490);
        repeat (20) @(posedge clk);
        rd(4'd5, 32'h1, "R2 channel 0 match");
        expect_item(1, 4'd0, 32'h0, "R4 irq masked");
        wr(4'd7, 32'h1);
        expect_item(1, 4'd0, 32'h1, "R4 irq enabled");
        wr(4'd7, 32'hF);
        expect_item(1, 4'd0, 32'h1, "R4 only matched channel raises");
        wr(4'd5, 32'h1);
        rd(4'd5, 32'h0, "R3 clear channel 0");
        expect_item(1, 4'd0, 32'h0, "R4 irq drops after clear");
        wr(4'd7, 32'h0);

        // clear colliding with a match
        wr(4'd0, 32'd2001);
        wr(4'd4, 32'd2000);
        wr(4'd5, 32'h1);
        rd(4'd5, 32'h1, "R3 set wins over clear");
        wr(4'd5, 32'h1);
        rd(4'd5, 32'h0, "R3 later clear");

        // channel 3 match with watchdog unarmed
        wr(4'd3, 32'h100);
        wr(4'd4, 32'hF0);
        for (int k = 1; k <= 20; k++)
            expect_item(2, 4'd0, 32'h0, "R6 no request when unarmed");
        rd(4'd5, 32'h8, "R2 channel 3 match");
        wr(4'd5, 32'h8);

        // set-only arming
        wr(4'd6, 32'h1);
        rd(4'd6, 32'h1, "R5 armed");
        wr(4'd6, 32'h0);
        rd(4'd6, 32'h1, "R5 write zero ignored");

        // watchdog expiry: pulse on checks 11..14
        wr(4'd3, 32'd3000);
        wr(4'd4, 32'd2990);
        for (int k = 1; k <= 15; k++)
            expect_item(2, 4'd0, (k >= 11 && k <= 14) ? 32'h1 : 32'h0,
                        "R6 watchdog pulse window");
        rd(4'd9, 32'h5, "R6 watchdog cause bit");
        rd(4'd5, 32'h8, "R2 watchdog channel status");
        wr(4'd9, 32'h5);
        rd(4'd9, 32'h0, "R8 cause write-one clear");

        // software reset command
        wr(4'd8, 32'h0);
        for (int k = 1; k <= 5; k++)
            expect_item(2, 4'd0, 32'h0, "R7 zero command ignored");
        rd(4'd9, 32'h0, "R7 zero command leaves cause");
        wr(4'd8, 32'h1);
        for (int k = 1; k <= 4; k++)
            expect_item(2, 4'd0, (k <= 3) ? 32'h1 : 32'h0, "R7 software pulse window");
        rd(4'd9, 32'h2, "R7 software cause bit");
        rd(4'd8, 32'h0, "R7 command reads zero");

        // sleep wake cause
        @(posedge clk); #1; sleep_rst_evt = 1'b1;
        @(posedge clk); #1; sleep_rst_evt = 1'b0;
        rd(4'd9, 32'hA, "R8 sleep cause bit");

        // system reset keeps arming and cause
        wr(4'd7, 32'h3);
        @(posedge clk); #1; sys_rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; sys_rst_n = 1'b1;
        rd(4'd4, 32'h1, "R10 counter restarted");
        rd(4'd6, 32'h1, "R10 arming kept");
        rd(4'd9, 32'hA, "R10 cause kept");
        rd(4'd5, 32'h0, "R10 status cleared");
        rd(4'd7, 32'h0, "R10 irq enable cleared");
        rd(4'd0, 32'hFFFF_FFFF, "R10 match register reset");

        // power-on reset
        @(posedge clk); #1; por_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; por_n = 1'b1;
        rd(4'd9, 32'h1, "R9 cause back to hardware");
        rd(4'd6, 32'h0, "R9 arming cleared");
        expect_item(2, 4'd0, 32'h0, "R9 no request after power-on");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule